// File: doc/BRIEF.md
# Cached Page Read Pipeline

This block models the two-stage read path of a NAND storage array. A page is first fetched from the array into a data register. It is then copied from that register into a cache register, and the host drains the cache one byte per read strobe. A plain start-read command fetches one page and makes it available at once. A cache-continue command copies the data register into the cache and then starts fetching the next sequential page into the data register, so that fetch runs while the host reads the cache. A cache-last command performs the copy without starting another fetch.

Commands arrive already decoded, as single-cycle requests with a page address and a starting column. The `ready` output is low while a foreground operation (a start-read fetch, a wait for a background fetch, or a copy) is in progress. A background fetch alone does not hold it low. The array contents are a fixed computed pattern. The fetch time and the copy time are parameters counted in clock cycles. Cache-mode reads may not run past the end of a block. A cache-continue that would do so is refused and raises `blk_err`.

Top module: `nand_cache_read`

## Requirements
- R1: After reset, `ready` is 1, `blk_err` is 0 and `dout` is 0.
- R2: A start-read accepted while `ready` is 1 holds `ready` low for exactly T_ARRAY cycles. Afterwards `dout` shows byte(page, col), where byte(p, c) is the low 8 bits of ((31·p + 7·c) XOR 0x5A).
- R3: Each cycle in which `rd_strobe` is 1 and `ready` is 1 advances the column by one. The column wraps from PAGE_BYTES-1 to 0, and `dout` follows it.
- R4: A cache-continue accepted while no fetch is running holds `ready` low for exactly T_COPY cycles. The cache then holds the data-register page, the column returns to the start column, and a fetch of the next page begins at that edge, lasting T_ARRAY cycles.
- R5: A cache-continue or cache-last accepted while a fetch is still running keeps `ready` low until that fetch ends, then for T_COPY more cycles. The copy then delivers the newly fetched page.
- R6: While `ready` is 1 and a background fetch runs, `dout` and the strobe act only on the cache contents. This holds even in the cycle the fetch completes.
- R7: A cache-continue may be issued after any number of strobes. The bytes not yet read from the previous page are dropped.
- R8: A cache-last copies the data register into the cache without starting a fetch. A second cache-last issued at once is busy exactly T_COPY cycles and returns the same page.
- R9: A cache-continue while the data-register page satisfies (page mod PAGES_PER_BLOCK) = PAGES_PER_BLOCK-1 is refused: `ready` stays 1, `dout` is unchanged and `blk_err` becomes 1. The next accepted command that is not refused clears `blk_err`.
- R10: Commands presented while `ready` is 0 are ignored. When several requests arrive together, start-read wins over cache-continue, which wins over cache-last.
- R11: A cache-continue accepted on the very edge a background fetch completes is busy exactly T_COPY cycles and delivers the newly fetched page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start | input | 1 | Start-read request |
| cmd_next | input | 1 | Cache-continue request |
| cmd_last | input | 1 | Cache-last request |
| page_addr | input | PAGE_W | Page to fetch on start-read |
| col_addr | input | COL_W | Starting column on start-read |
| rd_strobe | input | 1 | Advance the output column |
| ready | output | 1 | 1 = ready, 0 = busy |
| dout | output | 8 | Cache byte at the current column |
| blk_err | output | 1 | Set when a cache-continue is refused at a block end |

## Verification
Two events can land on the same edge: the background fetch completing, and either a cache-continue being accepted or a read strobe moving the column. The bench counts clock edges and aims commands exactly one edge before, on, and after the computed completion edge. It also places a strobe on the completion edge. The busy length and the delivered page are then compared with the values predicted by max(accept edge, fetch end) + T_COPY, and the byte under the strobe must still come from the old page.

// File: rtl/ncr_pkg.sv
package ncr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_COPY  = 2'd3
  } ctl_state_e;

  // Fixed array pattern: low byte of (31*page + 7*col) xor 0x5A
  function automatic logic [7:0] cell_byte(input int unsigned page, input int unsigned col);
    int unsigned v;
    v = (page * 32'd31 + col * 32'd7) ^ 32'h5A;
    return 8'(v);
  endfunction

endpackage

// File: rtl/ncr_array_reader.sv
module ncr_array_reader #(
  parameter int PAGE_BYTES = 8,
  parameter int NUM_PAGES  = 16,
  parameter int T_ARRAY    = 12,
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int CNT_W     = $clog2(T_ARRAY + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic [PAGE_W-1:0]           go_page,
  output logic                        busy,
  output logic                        done,
  output logic [PAGE_W-1:0]           page,
  output logic [PAGE_BYTES-1:0][7:0]  fetch_data,
  output logic [PAGE_BYTES-1:0][7:0]  dreg
);
  import ncr_pkg::*;

  logic                       busy_q, busy_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic [PAGE_W-1:0]          page_q, page_d;
  logic                       load_en;
  logic [PAGE_BYTES-1:0][7:0] dreg_q;

  // Array contents are computed per byte lane
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_cell
    assign fetch_data[b] = cell_byte(32'(page_q), 32'(b));
  end

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    page_d  = page_q;
    load_en = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(T_ARRAY - 1);
      page_d = go_page;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d  = 1'b0;
        load_en = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q <= '0;
    end else if (load_en) begin
      dreg_q <= fetch_data;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
  assign page = page_q;
  assign dreg = dreg_q;

endmodule

// File: rtl/ncr_cache_reg.sv
module ncr_cache_reg #(
  parameter int PAGE_BYTES = 8,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_fetch,
  input  logic [PAGE_BYTES-1:0][7:0]  fetch_data,
  input  logic                        load_dreg,
  input  logic [PAGE_BYTES-1:0][7:0]  dreg,
  input  logic [COL_W-1:0]            start_col,
  input  logic                        step,
  output logic [COL_W-1:0]            col,
  output logic [PAGE_BYTES-1:0][7:0]  cache,
  output logic [7:0]                  dout
);

  logic [PAGE_BYTES-1:0][7:0] cache_q, cache_d;
  logic [COL_W-1:0]           col_q, col_d;

  always_comb begin
    cache_d = cache_q;
    col_d   = col_q;
    if (load_fetch) begin
      cache_d = fetch_data;
      col_d   = start_col;
    end else if (load_dreg) begin
      cache_d = dreg;
      col_d   = start_col;
    end else if (step) begin
      col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_q <= '0;
      col_q   <= '0;
    end else begin
      cache_q <= cache_d;
      col_q   <= col_d;
    end
  end

  assign col   = col_q;
  assign cache = cache_q;
  assign dout  = cache_q[col_q];

endmodule

// File: rtl/ncr_ctrl.sv
module ncr_ctrl #(
  parameter int NUM_PAGES       = 16,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int PAGE_BYTES      = 8,
  parameter int T_COPY          = 3,
  localparam int PAGE_W         = $clog2(NUM_PAGES),
  localparam int COL_W          = $clog2(PAGE_BYTES),
  localparam int BLK_W          = $clog2(PAGES_PER_BLOCK),
  localparam int CP_W           = $clog2(T_COPY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_next,
  input  logic              cmd_last,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [PAGE_W-1:0] eng_page,
  output logic              eng_go,
  output logic [PAGE_W-1:0] eng_go_page,
  output logic              load_fetch,
  output logic              load_dreg,
  output logic [COL_W-1:0]  start_col,
  output logic              ready,
  output logic              blk_err,
  output logic              waiting
);
  import ncr_pkg::*;

  ctl_state_e       state_q, state_d;
  logic [CP_W-1:0]  cnt_q, cnt_d;
  logic             chain_q, chain_d;
  logic [COL_W-1:0] scol_q, scol_d;
  logic             err_q, err_d;
  logic             ready_q;
  logic             blk_end;

  assign blk_end = &eng_page[BLK_W-1:0];

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    chain_d     = chain_q;
    scol_d      = scol_q;
    err_d       = err_q;
    eng_go      = 1'b0;
    eng_go_page = eng_page + 1'b1;
    load_fetch  = 1'b0;
    load_dreg   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          state_d     = ST_FETCH;
          scol_d      = col_addr;
          err_d       = 1'b0;
          eng_go      = 1'b1;
          eng_go_page = page_addr;
        end else if (cmd_next || cmd_last) begin
          if (cmd_next && blk_end) begin
            err_d = 1'b1;
          end else begin
            err_d   = 1'b0;
            chain_d = cmd_next;
            if (eng_busy && !eng_done) begin
              state_d = ST_WAIT;
            end else begin
              state_d = ST_COPY;
              cnt_d   = CP_W'(T_COPY - 1);
            end
          end
        end
      end
      ST_FETCH: begin
        if (eng_done) begin
          load_fetch = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (eng_done) begin
          state_d = ST_COPY;
          cnt_d   = CP_W'(T_COPY - 1);
        end
      end
      ST_COPY: begin
        if (cnt_q == '0) begin
          load_dreg = 1'b1;
          eng_go    = chain_q;
          state_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      chain_q <= 1'b0;
      scol_q  <= '0;
      err_q   <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      chain_q <= chain_d;
      scol_q  <= scol_d;
      err_q   <= err_d;
      ready_q <= (state_d == ST_IDLE);
    end
  end

  assign start_col = scol_q;
  assign ready     = ready_q;
  assign blk_err   = err_q;
  assign waiting   = (state_q == ST_WAIT);

endmodule

// File: rtl/nand_cache_read.sv
module nand_cache_read #(
  parameter int PAGE_BYTES      = 8,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_BLOCKS      = 4,
  parameter int T_ARRAY         = 12,
  parameter int T_COPY          = 3,
  localparam int NUM_PAGES      = PAGES_PER_BLOCK * NUM_BLOCKS,
  localparam int PAGE_W         = $clog2(NUM_PAGES),
  localparam int COL_W          = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_next,
  input  logic              cmd_last,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              rd_strobe,
  output logic              ready,
  output logic [7:0]        dout,
  output logic              blk_err
);

  logic [1:0]                 rs_q;
  logic                       rst_sync_n;
  logic                       eng_go, eng_busy, eng_done;
  logic [PAGE_W-1:0]          eng_go_page, eng_page;
  logic [PAGE_BYTES-1:0][7:0] fetch_pg, dreg_pg, cache_pg;
  logic                       load_fetch, load_dreg, waiting;
  logic [COL_W-1:0]           start_col, col_ptr;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ncr_array_reader #(
    .PAGE_BYTES (PAGE_BYTES),
    .NUM_PAGES  (NUM_PAGES),
    .T_ARRAY    (T_ARRAY)
  ) u_reader (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go         (eng_go),
    .go_page    (eng_go_page),
    .busy       (eng_busy),
    .done       (eng_done),
    .page       (eng_page),
    .fetch_data (fetch_pg),
    .dreg       (dreg_pg)
  );

  ncr_ctrl #(
    .NUM_PAGES       (NUM_PAGES),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_BYTES      (PAGE_BYTES),
    .T_COPY          (T_COPY)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_start   (cmd_start),
    .cmd_next    (cmd_next),
    .cmd_last    (cmd_last),
    .page_addr   (page_addr),
    .col_addr    (col_addr),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .eng_page    (eng_page),
    .eng_go      (eng_go),
    .eng_go_page (eng_go_page),
    .load_fetch  (load_fetch),
    .load_dreg   (load_dreg),
    .start_col   (start_col),
    .ready       (ready),
    .blk_err     (blk_err),
    .waiting     (waiting)
  );

  ncr_cache_reg #(
    .PAGE_BYTES (PAGE_BYTES)
  ) u_cache (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_fetch (load_fetch),
    .fetch_data (fetch_pg),
    .load_dreg  (load_dreg),
    .dreg       (dreg_pg),
    .start_col  (start_col),
    .step       (ready && rd_strobe),
    .col        (col_ptr),
    .cache      (cache_pg),
    .dout       (dout)
  );

endmodule

// File: rtl/nand_cache_read_chk.sv
module nand_cache_read_chk #(
  parameter int PAGE_BYTES      = 8,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_PAGES       = 16,
  localparam int PAGE_W         = $clog2(NUM_PAGES),
  localparam int COL_W          = $clog2(PAGE_BYTES),
  localparam int BLK_W          = $clog2(PAGES_PER_BLOCK)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ready,
  input logic                       cmd_start,
  input logic                       cmd_next,
  input logic                       rd_strobe,
  input logic                       blk_err,
  input logic                       eng_busy,
  input logic [PAGE_W-1:0]          eng_page,
  input logic                       waiting,
  input logic [COL_W-1:0]           col,
  input logic [PAGE_BYTES-1:0][7:0] cache
);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_start) |=> !ready);

  // R3
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rd_strobe) |=> (col == COL_W'($past(col) + 1'b1)));

  // R5
  wait_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> eng_busy);

  // R6
  cache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(cache));

  // R9
  blk_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !cmd_start && cmd_next && (&eng_page[BLK_W-1:0])) |=> (ready && blk_err));

endmodule

bind nand_cache_read nand_cache_read_chk #(
  .PAGE_BYTES      (PAGE_BYTES),
  .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
  .NUM_PAGES       (NUM_PAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ready     (ready),
  .cmd_start (cmd_start),
  .cmd_next  (cmd_next),
  .rd_strobe (rd_strobe),
  .blk_err   (blk_err),
  .eng_busy  (eng_busy),
  .eng_page  (eng_page),
  .waiting   (waiting),
  .col       (col_ptr),
  .cache     (cache_pg)
);

// File: tb/nand_cache_read_bench.sv
module nand_cache_read_bench;
  localparam int PB  = 8;
  localparam int PPB = 4;
  localparam int NB  = 4;
  localparam int TA  = 12;
  localparam int TC  = 3;
  localparam int NP  = PPB * NB;
  localparam int PW  = $clog2(NP);
  localparam int CW  = $clog2(PB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_start, cmd_next, cmd_last, rd_strobe;
  logic [PW-1:0] page_addr;
  logic [CW-1:0] col_addr;
  logic          ready, blk_err;
  logic [7:0]    dout;

  always #4 clk = ~clk;

  nand_cache_read #(
    .PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB), .NUM_BLOCKS(NB), .T_ARRAY(TA), .T_COPY(TC)
  ) u_nand_cache_read (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_next(cmd_next),
    .cmd_last(cmd_last), .page_addr(page_addr), .col_addr(col_addr),
    .rd_strobe(rd_strobe), .ready(ready), .dout(dout), .blk_err(blk_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state
  int m_cache_page, m_col, m_start_col, m_eng_page, m_bg_d;

  function automatic int exp_byte(input int p, input int c);
    return ((p * 31 + c * 7) ^ 32'h5A) & 32'hFF;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic send(input bit s, input bit n, input bit l, input int p, input int c,
                      input int at_k, output int k);
    if (at_k > 0) begin
      while (cyc < at_k - 1) @(negedge clk);
    end else begin
      @(negedge clk);
    end
    cmd_start = s; cmd_next = n; cmd_last = l;
    page_addr = PW'(p); col_addr = CW'(c);
    k = cyc + 1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_next = 1'b0; cmd_last = 1'b0;
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (ready !== 1'b1 && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic do_start(input int p, input int c, input string req);
    int k;
    send(1'b1, 1'b0, 1'b0, p, c, 0, k);
    wait_ready();
    chk({req, " start busy"}, cyc - k, TA);
    m_eng_page = p; m_bg_d = k + TA; m_cache_page = p;
    m_col = c; m_start_col = c;
    chk({req, " start data"}, dout, exp_byte(p, c));
    chk("R9 cleared by start", blk_err, 0);
  endtask

  // kind: 1 = cache-continue, 0 = cache-last
  task automatic do_cache(input bit is_next, input int at_k, input string req);
    int k, e, d0;
    string lbl;
    d0 = m_bg_d;
    send(1'b0, is_next, !is_next, 0, 0, at_k, k);
    if (is_next && (m_eng_page % PPB == PPB - 1)) begin
      chk("R9 refused ready", ready, 1);
      chk("R9 refused flag", blk_err, 1);
      chk("R9 refused data", dout, exp_byte(m_cache_page, m_col));
    end else begin
      e = ((k > d0) ? k : d0) + TC;
      if (d0 > k)       lbl = "R5";
      else if (d0 == k) lbl = "R11";
      else              lbl = "R4";
      wait_ready();
      chk({lbl, " busy length ", req}, cyc - k, e - k);
      m_cache_page = m_eng_page;
      m_col = m_start_col;
      if (is_next) begin
        m_eng_page = m_eng_page + 1;
        m_bg_d = e + TA;
      end
      chk({lbl, " copied page ", req}, dout, exp_byte(m_cache_page, m_col));
      chk("R9 cleared", blk_err, 0);
    end
  endtask

  task automatic read_bytes(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " serial byte"}, dout, exp_byte(m_cache_page, m_col));
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      m_col = (m_col + 1) % PB;
    end
    chk({req, " after strobes"}, dout, exp_byte(m_cache_page, m_col));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual %0d expected finish", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k, t;
    int unsigned seed_v;
    rst_n = 1'b0;
    cmd_start = 1'b0; cmd_next = 1'b0; cmd_last = 1'b0; rd_strobe = 1'b0;
    page_addr = '0; col_addr = '0;
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", ready, 1);
    chk("R1 blk_err", blk_err, 0);
    chk("R1 dout", dout, 0);

    // R2 / R3: plain read, full wrap of the page
    do_start(5, 2, "R2");
    read_bytes(PB, "R3");

    // R4: engine idle, copy only
    do_cache(1'b1, 0, "R4 idle");
    // R6 / R7: partial read during background fetch, then continue early
    read_bytes(3, "R6");
    do_cache(1'b1, 0, "R7 partial");
    // R9: data register holds page 7, last of its block
    do_cache(1'b1, 0, "R9");
    // R8: last waits for fetch, then second last is pure copy
    do_cache(1'b0, 0, "R8 first");
    do_cache(1'b0, 0, "R8 second");

    // R10: commands during busy are ignored
    send(1'b1, 1'b0, 1'b0, 9, 0, 0, k);
    cmd_next = 1'b1; @(negedge clk); cmd_next = 1'b0;
    cmd_last = 1'b1; @(negedge clk); cmd_last = 1'b0;
    wait_ready();
    chk("R10 busy unchanged", cyc - k, TA);
    m_eng_page = 9; m_bg_d = k + TA; m_cache_page = 9; m_col = 0; m_start_col = 0;
    repeat (3) @(negedge clk);
    chk("R10 stays ready", ready, 1);
    chk("R10 data", dout, exp_byte(9, 0));

    // R10: priority start over next and last
    send(1'b1, 1'b1, 1'b1, 13, 5, 0, k);
    wait_ready();
    chk("R10 priority busy", cyc - k, TA);
    m_eng_page = 13; m_bg_d = k + TA; m_cache_page = 13; m_col = 5; m_start_col = 5;
    chk("R10 priority data", dout, exp_byte(13, 5));

    // R11: coincidence of fetch completion and command acceptance
    do_start(8, 1, "R2");
    do_cache(1'b1, 0, "R4 first");        // cache 8, fetching 9
    do_cache(1'b1, m_bg_d, "R11 on edge");  // cache 9, fetching 10
    do_cache(1'b1, m_bg_d - 1, "R5 one early"); // cache 10, fetching 11
    // R6: strobe on the fetch completion edge still reads the cache
    t = m_bg_d;
    while (cyc < t - 1) @(negedge clk);
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    m_col = (m_col + 1) % PB;
    chk("R6 strobe on completion edge", dout, exp_byte(10, m_col));
    do_cache(1'b1, 0, "R9 second");       // page 11 refused
    do_cache(1'b0, m_bg_d + 1, "R4 last after fetch");

    // Constrained random mix
    for (int i = 0; i < 60; i++) begin
      int r, gap;
      r = $urandom_range(0, 9);
      gap = $urandom_range(0, 14);
      repeat (gap) @(negedge clk);
      if (r == 0)      do_start($urandom_range(0, NP - 1), $urandom_range(0, PB - 1), "R2 rnd");
      else if (r <= 4) do_cache(1'b1, 0, "rnd");
      else if (r == 5) do_cache(1'b0, 0, "R8 rnd");
      else             read_bytes($urandom_range(1, 9), "R3 rnd");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule